// File: doc/BRIEF.md
# Interrupt Priority Acceptance Unit

This unit gathers pending interrupt requests from four kinds of source and decides which one, if any, the processor takes next. The sources are a non-maskable pin, a debug-port interrupt command, eight external request lines, and a parameterised vector of on-chip peripheral requests. Every maskable request carries a 4-bit priority. The non-maskable source sits at level 16 and the debug command at level 15. The winner must beat the processor's current 4-bit mask and respect the status block bit. It is taken only when the core signals an instruction boundary.

On acceptance the unit raises a one-cycle `take` pulse. With it come the event code, the vector offset, and strobes that tell the core to save the program counter and status word, set the block and register-bank bits, and, for maskable sources, load a new mask level. Saving registers and fetching the vector are done outside this unit.

Top module: `prio_accept`

## Requirements
- R1: After reset `take`, `load_imask`, `evt_code` and `new_imask` are all zero.
- R2: An external or peripheral request is eligible only when its priority is strictly greater than `sr_imask` and `sr_bl` is 0. A priority of 0 is never eligible. Accepting such a request pulses `load_imask` with `new_imask` equal to its priority.
- R3: The eligible source with the highest level wins. Equal levels are resolved in this order: non-maskable, then debug, then external line 7 down to line 0, then peripherals from index 0 upward. External line k, whose priority is `ext_prio[4k+3:4k]`, reports code 0x200+0x20·k. Peripheral i, whose priority is `per_prio[4i+3:4i]`, reports code 0x400+0x20·i.
- R4: A decision is made only in a cycle with `insn_boundary` high. `take` rises in the following cycle and lasts one cycle. A boundary in the same cycle as `take` is not used.
- R5: The non-maskable pin passes through a two-stage synchroniser and is edge-detected. `nmi_rise`=1 selects the rising edge and 0 the falling edge. A detected edge stays pending until accepted. It is accepted when `sr_bl` is 0 or `low_power` is 1, regardless of `sr_imask`. It reports code 0x1C0 and leaves `load_imask` at 0.
- R6: A `dbg_cmd` pulse latches a debug request that stays pending until accepted. It is accepted only when `sr_imask` is below 15 and `sr_bl` is 0. It reports code 0x5E0 and leaves `load_imask` at 0.
- R7: Every acceptance pulses `save_ctx`, `set_bl` and `set_rb` together with `take`, and drives `vec_ofs` to 0x600.
- R8: With `sr_bl` at 1, nothing is accepted except a pending non-maskable edge while `low_power` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_boundary | input | 1 | Core is between two instructions |
| sr_imask | input | 4 | Current interrupt mask level |
| sr_bl | input | 1 | Status block bit |
| low_power | input | 1 | Core is in sleep or standby |
| nmi_pin | input | 1 | Asynchronous non-maskable input |
| nmi_rise | input | 1 | Edge select: 1 rising, 0 falling |
| dbg_cmd | input | 1 | Debug interrupt command pulse |
| ext_req | input | 8 | External request levels |
| ext_prio | input | 32 | Four-bit priority per external line |
| per_req | input | NPER | Peripheral request levels |
| per_prio | input | 4·NPER | Four-bit priority per peripheral |
| take | output | 1 | Acceptance pulse |
| evt_code | output | 12 | Event code of the last accepted source |
| vec_ofs | output | 12 | Vector offset from the vector base |
| save_ctx | output | 1 | Save PC and status word |
| set_bl | output | 1 | Set the block bit |
| set_rb | output | 1 | Set the register-bank bit |
| load_imask | output | 1 | Load `new_imask` into the mask |
| new_imask | output | 4 | Mask level to load |

## Verification
Arbitration is combinational on the inputs present in the boundary cycle, and a single register stage follows it. As a result `take`, the strobes and the code fields become valid one clock after the boundary cycle. The bench drives inputs on a falling edge, holds the boundary for exactly one rising edge, and samples on the next falling edge. A non-maskable edge needs two synchroniser stages plus the pending register before it can win, so the bench waits four cycles after moving the pin before it offers a boundary. The one-cycle `take` rule is checked by holding the boundary for two edges and looking at both falling edges that follow.

// File: rtl/prio_accept.sv
module prio_accept #(
  parameter int          NPER      = 8,
  parameter logic [11:0] IRQ_BASE  = 12'h200,
  parameter logic [11:0] PER_BASE  = 12'h400,
  parameter logic [11:0] CODE_STEP = 12'h020,
  parameter logic [11:0] NMI_CODE  = 12'h1C0,
  parameter logic [11:0] DBG_CODE  = 12'h5E0,
  parameter logic [11:0] VEC_INT   = 12'h600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic [3:0]        sr_imask,
  input  logic              sr_bl,
  input  logic              low_power,
  input  logic              nmi_pin,
  input  logic              nmi_rise,
  input  logic              dbg_cmd,
  input  logic [7:0]        ext_req,
  input  logic [31:0]       ext_prio,
  input  logic [NPER-1:0]   per_req,
  input  logic [4*NPER-1:0] per_prio,
  output logic              take,
  output logic [11:0]       evt_code,
  output logic [11:0]       vec_ofs,
  output logic              save_ctx,
  output logic              set_bl,
  output logic              set_rb,
  output logic              load_imask,
  output logic [3:0]        new_imask
);
  localparam logic [1:0] K_NONE = 2'd0, K_NMI = 2'd1, K_DBG = 2'd2, K_MSK = 2'd3;

  logic [2:0]  nmi_sy;
  logic        nmi_edge, nmi_pend, dbg_pend;
  logic [4:0]  best_lvl;
  logic [11:0] best_code;
  logic [1:0]  best_kind;
  logic        go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nmi_sy <= '0;
    else        nmi_sy <= {nmi_sy[1:0], nmi_pin};

  assign nmi_edge = nmi_rise ? (nmi_sy[1] & ~nmi_sy[2]) : (~nmi_sy[1] & nmi_sy[2]);

  always_comb begin
    best_lvl  = 5'd0;
    best_code = 12'h000;
    best_kind = K_NONE;
    if (nmi_pend && (!sr_bl || low_power)) begin
      best_lvl  = 5'd16;
      best_code = NMI_CODE;
      best_kind = K_NMI;
    end
    if (dbg_pend && !sr_bl && sr_imask != 4'hF && 5'd15 > best_lvl) begin
      best_lvl  = 5'd15;
      best_code = DBG_CODE;
      best_kind = K_DBG;
    end
    for (int k = 7; k >= 0; k--) begin
      if (ext_req[k] && !sr_bl &&
          {1'b0, ext_prio[4*k +: 4]} > {1'b0, sr_imask} &&
          {1'b0, ext_prio[4*k +: 4]} > best_lvl) begin
        best_lvl  = {1'b0, ext_prio[4*k +: 4]};
        best_code = IRQ_BASE + CODE_STEP * 12'(k);
        best_kind = K_MSK;
      end
    end
    for (int i = 0; i < NPER; i++) begin
      if (per_req[i] && !sr_bl &&
          {1'b0, per_prio[4*i +: 4]} > {1'b0, sr_imask} &&
          {1'b0, per_prio[4*i +: 4]} > best_lvl) begin
        best_lvl  = {1'b0, per_prio[4*i +: 4]};
        best_code = PER_BASE + CODE_STEP * 12'(i);
        best_kind = K_MSK;
      end
    end
  end

  assign go = insn_boundary && (best_kind != K_NONE) && !take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nmi_pend <= 1'b0;
      dbg_pend <= 1'b0;
    end else begin
      if (nmi_edge)                          nmi_pend <= 1'b1;
      else if (go && best_kind == K_NMI)     nmi_pend <= 1'b0;
      if (dbg_cmd)                           dbg_pend <= 1'b1;
      else if (go && best_kind == K_DBG)     dbg_pend <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      take       <= 1'b0;
      load_imask <= 1'b0;
      evt_code   <= '0;
      vec_ofs    <= '0;
      new_imask  <= '0;
    end else begin
      take       <= go;
      load_imask <= go && best_kind == K_MSK;
      if (go) begin
        evt_code <= best_code;
        vec_ofs  <= VEC_INT;
        if (best_kind == K_MSK) new_imask <= best_lvl[3:0];
      end
    end

  assign save_ctx = take;
  assign set_bl   = take;
  assign set_rb   = take;
endmodule

module prio_accept_chk #(
  parameter logic [11:0] NMI_CODE = 12'h1C0,
  parameter logic [11:0] DBG_CODE = 12'h5E0,
  parameter logic [11:0] VEC_INT  = 12'h600
) (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_boundary,
  input logic [3:0]  sr_imask,
  input logic        sr_bl,
  input logic        low_power,
  input logic        take,
  input logic [11:0] evt_code,
  input logic [11:0] vec_ofs,
  input logic        load_imask,
  input logic [3:0]  new_imask
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) take |=> !take);
  a_r4_on_boundary: assert property (@(posedge clk) disable iff (!rst_n) take |-> $past(insn_boundary));
  a_r2_strict_mask: assert property (@(posedge clk) disable iff (!rst_n)
    load_imask |-> (new_imask > $past(sr_imask)) && !$past(sr_bl));
  a_r5_nmi_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evt_code == NMI_CODE) |-> !load_imask);
  a_r6_dbg_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evt_code == DBG_CODE) |-> ($past(sr_imask) != 4'hF) && !$past(sr_bl) && !load_imask);
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n) take |-> vec_ofs == VEC_INT);
  a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(sr_bl)) |-> $past(low_power) && evt_code == NMI_CODE);
  a_r1_load_with_take: assert property (@(posedge clk) disable iff (!rst_n) load_imask |-> take);
endmodule

bind prio_accept prio_accept_chk #(.NMI_CODE(NMI_CODE), .DBG_CODE(DBG_CODE), .VEC_INT(VEC_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .sr_imask(sr_imask),
  .sr_bl(sr_bl), .low_power(low_power), .take(take), .evt_code(evt_code),
  .vec_ofs(vec_ofs), .load_imask(load_imask), .new_imask(new_imask)
);

// File: tb/sim_prio_accept.sv
module sim_prio_accept;
  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_boundary = 0, sr_bl = 0, low_power = 0, nmi_pin = 0, nmi_rise = 1, dbg_cmd = 0;
  logic [3:0] sr_imask = 0;
  logic [7:0] ext_req = 0;
  logic [31:0] ext_prio = 0;
  logic [7:0] per_req = 0;
  logic [31:0] per_prio = 0;
  logic take, save_ctx, set_bl, set_rb, load_imask;
  logic [11:0] evt_code, vec_ofs;
  logic [3:0] new_imask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_accept u0 (.*);

  // ext_req, ext_prio, per_req, per_prio, imask, bl | take, code, load, mask
  localparam int NV = 11;
  localparam logic [102:0] VEC [NV] = '{
    {8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000, 4'h0, 1'b0, 1'b0, 12'h000, 1'b0, 4'h0},
    {8'h08, 32'h0000_5000, 8'h00, 32'h0000_0000, 4'h4, 1'b0, 1'b1, 12'h260, 1'b1, 4'h5},
    {8'h08, 32'h0000_5000, 8'h00, 32'h0000_0000, 4'h5, 1'b0, 1'b0, 12'h000, 1'b0, 4'h0},
    {8'h08, 32'h0000_0000, 8'h00, 32'h0000_0000, 4'h0, 1'b0, 1'b0, 12'h000, 1'b0, 4'h0},
    {8'h24, 32'h0070_0700, 8'h00, 32'h0000_0000, 4'h0, 1'b0, 1'b1, 12'h2A0, 1'b1, 4'h7},
    {8'h01, 32'h0000_0009, 8'h04, 32'h0000_0900, 4'h0, 1'b0, 1'b1, 12'h200, 1'b1, 4'h9},
    {8'h00, 32'h0000_0000, 8'h42, 32'h0C00_0030, 4'h2, 1'b0, 1'b1, 12'h4C0, 1'b1, 4'hC},
    {8'h00, 32'h0000_0000, 8'h30, 32'h0066_0000, 4'h1, 1'b0, 1'b1, 12'h480, 1'b1, 4'h6},
    {8'h80, 32'hF000_0000, 8'h00, 32'h0000_0000, 4'h0, 1'b1, 1'b0, 12'h000, 1'b0, 4'h0},
    {8'h02, 32'h0000_0020, 8'h01, 32'h0000_000E, 4'hD, 1'b0, 1'b1, 12'h400, 1'b1, 4'hE},
    {8'h80, 32'hF000_0000, 8'h01, 32'h0000_000F, 4'hE, 1'b0, 1'b1, 12'h2E0, 1'b1, 4'hF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic boundary();
    insn_boundary = 1;
    @(negedge clk);
    insn_boundary = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_src();
    ext_req = 0; ext_prio = 0; per_req = 0; per_prio = 0;
    sr_imask = 0; sr_bl = 0; low_power = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    check("R1 take", take, 0);
    check("R1 load_imask", load_imask, 0);
    check("R1 evt_code", evt_code, 0);
    check("R1 new_imask", new_imask, 0);
    rst_n = 1;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      {ext_req, ext_prio, per_req, per_prio, sr_imask, sr_bl} = VEC[v][102:18];
      boundary();
      check($sformatf("R2/R3/R8 vec%0d take", v), take, VEC[v][17]);
      check($sformatf("R2 vec%0d load", v), load_imask, VEC[v][4]);
      if (VEC[v][17]) begin
        check($sformatf("R3 vec%0d code", v), evt_code, VEC[v][16:5]);
        check($sformatf("R2 vec%0d mask", v), new_imask, VEC[v][3:0]);
      end
      idle(1);
    end

    clear_src();
    ext_req = 8'h02; ext_prio = 32'h0000_0030;
    idle(2);
    check("R4 no boundary", take, 0);
    insn_boundary = 1;
    @(negedge clk);
    check("R4 take first", take, 1);
    check("R7 save_ctx", save_ctx, 1);
    check("R7 set_bl", set_bl, 1);
    check("R7 set_rb", set_rb, 1);
    check("R7 vec_ofs", vec_ofs, 12'h600);
    check("R3 code irq1", evt_code, 12'h220);
    @(negedge clk);
    check("R4 single pulse", take, 0);
    check("R7 strobe drop", save_ctx, 0);
    insn_boundary = 0;
    idle(1);

    clear_src();
    sr_imask = 4'hF;
    dbg_cmd = 1; @(negedge clk); dbg_cmd = 0;
    boundary();
    check("R6 mask 15 blocks", take, 0);
    idle(1);
    sr_imask = 4'hE;
    boundary();
    check("R6 take", take, 1);
    check("R6 code", evt_code, 12'h5E0);
    check("R6 no load", load_imask, 0);
    check("R7 dbg vec", vec_ofs, 12'h600);
    idle(1);
    boundary();
    check("R6 cleared", take, 0);
    idle(1);

    clear_src();
    ext_req = 8'h10; ext_prio = 32'h000F_0000;
    dbg_cmd = 1; @(negedge clk); dbg_cmd = 0;
    boundary();
    check("R3 debug over irq4", evt_code, 12'h5E0);
    idle(1);
    boundary();
    check("R3 irq4 next", evt_code, 12'h280);
    check("R2 irq4 mask", new_imask, 4'hF);
    idle(1);

    clear_src();
    dbg_cmd = 1; @(negedge clk); dbg_cmd = 0;
    sr_bl = 1;
    boundary();
    check("R8 debug blocked", take, 0);
    idle(1);
    sr_bl = 0;
    boundary();
    check("R6 debug after unblock", evt_code, 12'h5E0);
    idle(1);

    clear_src();
    nmi_rise = 1; nmi_pin = 1;
    idle(4);
    sr_bl = 1;
    boundary();
    check("R8 nmi blocked", take, 0);
    idle(1);
    low_power = 1;
    boundary();
    check("R5 nmi in low power", take, 1);
    check("R5 nmi code", evt_code, 12'h1C0);
    check("R5 nmi keeps mask", load_imask, 0);
    idle(1);
    boundary();
    check("R5 nmi cleared", take, 0);
    idle(1);

    clear_src();
    ext_req = 8'h80; ext_prio = 32'hF000_0000; sr_imask = 4'hF;
    nmi_rise = 0; nmi_pin = 0;
    idle(4);
    boundary();
    check("R5 falling edge take", take, 1);
    check("R5 nmi beats mask 15", evt_code, 12'h1C0);
    idle(1);
    boundary();
    check("R2 irq7 at mask 15 ignored", take, 0);
    idle(1);
    nmi_pin = 1;
    idle(4);
    boundary();
    check("R5 rising ignored when falling selected", take, 0);
    idle(1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule